// File: doc/BRIEF.md
# Writeback Port Arbiter

Four execution units (integer, FP add/subtract, FP multiply, FP divide) share one register-file write port. Each unit that has a finished result raises a request and presents the issue sequence number of that instruction. In the same cycle the arbiter grants the port to exactly one requester. Every other requester receives a hold, so it keeps its result and stays busy until a later grant. Per-unit latency and a non-pipelined flag are static configuration inputs. A unit that is held while pipelined must freeze its whole internal pipeline.

Priority is decided by three keys in turn. A non-pipelined unit beats a pipelined one. Within the same class, the longer configured latency wins. On a further tie, the older instruction wins. Sequence numbers are 8-bit wrapping counters compared modulo 256, with at most 128 instructions in flight. The decision is purely combinational on the current inputs. The granted result is captured into a one-entry writeback stage register, whose outputs drive the register-file write.

Top module: `wb_port_arbiter`

## Requirements
- R1: When at least one request is raised, exactly one grant bit is set. When no request is raised, no grant bit is set.
- R2: A grant bit is set only for a unit whose request bit is set.
- R3: In the same cycle, hold is exactly the request vector with the granted bit cleared.
- R4: A requesting unit flagged non-pipelined wins over every requesting pipelined unit, whatever their latencies.
- R5: Among requesters of the same pipelining class, the one with the greater configured latency wins.
- R6: Among requesters with equal class and latency, the older instruction wins. Sequence a is older than b when (b - a) mod 256 lies in 1..127, so 250 is older than 3.
- R7: When class, latency and sequence number are all equal, the unit with the lower index wins. The indices are integer=0, add=1, multiply=2, divide=3.
- R8: Grant and hold depend only on the current inputs. A unit that won or lost in the previous cycle gets no preference.
- R9: On the clock edge after a cycle with a grant, wb_valid_o is 1 and wb_unit_o and wb_seq_o carry the granted unit index and its sequence number. After a cycle with no request, wb_valid_o is 0 and wb_unit_o and wb_seq_o keep their previous values.
- R10: While rst_n is low, wb_valid_o, wb_unit_o and wb_seq_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_UNITS | Result-ready request per unit |
| seq_i | input | N_UNITS*8 | Issue sequence number per unit, unit i in bits [8i+7:8i] |
| lat_i | input | N_UNITS*6 | Configured latency per unit, unit i in bits [6i+5:6i] |
| unpiped_i | input | N_UNITS | 1 = unit is non-pipelined |
| grant_o | output | N_UNITS | One-hot write-port grant |
| hold_o | output | N_UNITS | Stall for requesters that lost |
| wb_valid_o | output | 1 | Writeback stage holds a result this cycle |
| wb_unit_o | output | 2 | Index of the unit in the writeback stage |
| wb_seq_o | output | 8 | Sequence number in the writeback stage |

## Verification
Grant and hold are combinational, so each directed task applies its inputs on a falling edge and samples them a quarter period later, before any rising edge. The writeback-stage outputs sit behind one register. They are sampled on the next falling edge, one rising edge after the stimulus, and are compared with the unit and sequence number that were granted in the cycle before. The priority scenarios set the configuration so that only one key can decide each contest: class against latency, latency alone, age including wrap-around, and a full tie.

// File: rtl/wb_arb_pkg.sv
package wb_arb_pkg;
  parameter int unsigned SEQ_W = 8;
  parameter int unsigned LAT_W = 6;
  parameter int unsigned IDX_W = 8;

  typedef struct packed {
    logic             vld;
    logic             unpiped;
    logic [LAT_W-1:0] lat;
    logic [SEQ_W-1:0] seq;
    logic [IDX_W-1:0] idx;
  } cand_t;

  // a is older than b when (b - a) lies in the lower half of the ring
  function automatic logic seq_older(input logic [SEQ_W-1:0] a,
                                     input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] diff;
    diff = b - a;
    return (diff != '0) && !diff[SEQ_W-1];
  endfunction
endpackage

// File: rtl/wb_pair_pick.sv
module wb_pair_pick
  import wb_arb_pkg::*;
(
  input  cand_t lo_i,   // candidate from the lower-index subtree
  input  cand_t hi_i,   // candidate from the higher-index subtree
  output cand_t win_o
);
  logic take_lo;

  always_comb begin
    if (!hi_i.vld) begin
      take_lo = 1'b1;
    end else if (!lo_i.vld) begin
      take_lo = 1'b0;
    end else if (lo_i.unpiped != hi_i.unpiped) begin
      take_lo = lo_i.unpiped;
    end else if (lo_i.lat != hi_i.lat) begin
      take_lo = (lo_i.lat > hi_i.lat);
    end else begin
      // equal age falls back to the lower index
      take_lo = !seq_older(hi_i.seq, lo_i.seq);
    end
  end

  assign win_o = take_lo ? lo_i : hi_i;
endmodule

// File: rtl/wb_grant_dec.sv
module wb_grant_dec #(
  parameter int unsigned N_UNITS = 4,
  parameter int unsigned UNIT_W  = 2
) (
  input  logic              vld_i,
  input  logic [UNIT_W-1:0] idx_i,
  output logic [N_UNITS-1:0] onehot_o
);
  for (genvar g = 0; g < N_UNITS; g++) begin : g_bit
    assign onehot_o[g] = vld_i && (idx_i == UNIT_W'(g));
  end
endmodule

// File: rtl/wb_port_arbiter.sv
module wb_port_arbiter
  import wb_arb_pkg::*;
#(
  parameter int unsigned N_UNITS = 4,
  localparam int unsigned UNIT_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_UNITS-1:0]       req_i,
  input  logic [N_UNITS*SEQ_W-1:0] seq_i,
  input  logic [N_UNITS*LAT_W-1:0] lat_i,
  input  logic [N_UNITS-1:0]       unpiped_i,
  output logic [N_UNITS-1:0]       grant_o,
  output logic [N_UNITS-1:0]       hold_o,
  output logic                     wb_valid_o,
  output logic [UNIT_W-1:0]        wb_unit_o,
  output logic [SEQ_W-1:0]         wb_seq_o
);
  localparam int unsigned LEAVES = 1 << UNIT_W;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  // heap-ordered tournament tree: node k has children 2k+1 (lower) and 2k+2
  cand_t node [NODES];
  cand_t winner;

  for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
    if (l < N_UNITS) begin : g_real
      assign node[LEAVES-1+l] = '{vld:     req_i[l],
                                  unpiped: unpiped_i[l],
                                  lat:     lat_i[l*LAT_W +: LAT_W],
                                  seq:     seq_i[l*SEQ_W +: SEQ_W],
                                  idx:     IDX_W'(l)};
    end else begin : g_pad
      assign node[LEAVES-1+l] = '0;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    wb_pair_pick u_pick (
      .lo_i  (node[2*k+1]),
      .hi_i  (node[2*k+2]),
      .win_o (node[k])
    );
  end

  assign winner = node[0];

  wb_grant_dec #(.N_UNITS(N_UNITS), .UNIT_W(UNIT_W)) u_dec (
    .vld_i    (winner.vld),
    .idx_i    (winner.idx[UNIT_W-1:0]),
    .onehot_o (grant_o)
  );

  assign hold_o = req_i & ~grant_o;

  // writeback stage register
  logic              wb_valid_d, wb_valid_q;
  logic [UNIT_W-1:0] wb_unit_d,  wb_unit_q;
  logic [SEQ_W-1:0]  wb_seq_d,   wb_seq_q;
  logic              wb_load_en;

  always_comb begin
    wb_load_en = winner.vld;
    wb_valid_d = winner.vld;
    wb_unit_d  = winner.idx[UNIT_W-1:0];
    wb_seq_d   = winner.seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid_q <= 1'b0;
      wb_unit_q  <= '0;
      wb_seq_q   <= '0;
    end else begin
      wb_valid_q <= wb_valid_d;
      if (wb_load_en) begin
        wb_unit_q <= wb_unit_d;
        wb_seq_q  <= wb_seq_d;
      end
    end
  end

  assign wb_valid_o = wb_valid_q;
  assign wb_unit_o  = wb_unit_q;
  assign wb_seq_o   = wb_seq_q;
endmodule

// File: rtl/wb_arb_chk.sv
module wb_arb_chk
  import wb_arb_pkg::*;
#(
  parameter int unsigned N_UNITS = 4,
  parameter int unsigned UNIT_W  = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_UNITS-1:0]       req_i,
  input logic [N_UNITS*SEQ_W-1:0] seq_i,
  input logic [N_UNITS*LAT_W-1:0] lat_i,
  input logic [N_UNITS-1:0]       unpiped_i,
  input logic [N_UNITS-1:0]       grant_o,
  input logic [N_UNITS-1:0]       hold_o,
  input logic                     wb_valid_o,
  input logic [UNIT_W-1:0]        wb_unit_o,
  input logic [SEQ_W-1:0]         wb_seq_o
);
  logic [UNIT_W-1:0] g_idx;
  logic [SEQ_W-1:0]  g_seq;

  always_comb begin
    g_idx = '0;
    g_seq = '0;
    for (int u = 0; u < N_UNITS; u++) begin
      if (grant_o[u]) begin
        g_idx = UNIT_W'(u);
        g_seq = seq_i[u*SEQ_W +: SEQ_W];
      end
    end
  end

  // R1
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> $countones(grant_o) == 1);
  // R1
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_i) |-> grant_o == '0);
  // R2
  grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~req_i) == '0);
  // R3
  hold_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hold_o & grant_o) == '0) && ((hold_o | grant_o) == req_i));
  // R9
  wb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_o) |=> wb_valid_o && wb_unit_o == $past(g_idx) && wb_seq_o == $past(g_seq));
  // R9
  wb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_i) |=> !wb_valid_o && $stable(wb_unit_o) && $stable(wb_seq_o));
  // R10
  wb_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (wb_valid_o == 1'b0 || rst_n) && (wb_unit_o == '0 || rst_n) && (wb_seq_o == '0 || rst_n));

  for (genvar i = 0; i < N_UNITS; i++) begin : g_w
    for (genvar j = 0; j < N_UNITS; j++) begin : g_l
      if (i != j) begin : g_pair
        localparam bit W_LOWER = (i < j);
        // R4
        class_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (grant_o[i] && req_i[j] && unpiped_i[j]) |-> unpiped_i[i]);
        // R5
        lat_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (grant_o[i] && req_i[j] && unpiped_i[i] == unpiped_i[j])
          |-> lat_i[i*LAT_W +: LAT_W] >= lat_i[j*LAT_W +: LAT_W]);
        // R6 R7
        age_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (grant_o[i] && req_i[j] && unpiped_i[i] == unpiped_i[j] &&
           lat_i[i*LAT_W +: LAT_W] == lat_i[j*LAT_W +: LAT_W])
          |-> !seq_older(seq_i[j*SEQ_W +: SEQ_W], seq_i[i*SEQ_W +: SEQ_W]) &&
              (seq_i[j*SEQ_W +: SEQ_W] != seq_i[i*SEQ_W +: SEQ_W] || W_LOWER));
      end
    end
  end
endmodule

bind wb_port_arbiter wb_arb_chk #(.N_UNITS(N_UNITS), .UNIT_W(UNIT_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .seq_i      (seq_i),
  .lat_i      (lat_i),
  .unpiped_i  (unpiped_i),
  .grant_o    (grant_o),
  .hold_o     (hold_o),
  .wb_valid_o (wb_valid_o),
  .wb_unit_o  (wb_unit_o),
  .wb_seq_o   (wb_seq_o)
);

// File: tb/test_wb_port_arbiter.sv
module test_wb_port_arbiter;
  logic        clk;
  logic        rst_n;
  logic [3:0]  req_i;
  logic [31:0] seq_i;
  logic [23:0] lat_i;
  logic [3:0]  unpiped_i;
  logic [3:0]  grant_o;
  logic [3:0]  hold_o;
  logic        wb_valid_o;
  logic [1:0]  wb_unit_o;
  logic [7:0]  wb_seq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  wb_port_arbiter #(.N_UNITS(4)) i_wb_port_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .seq_i(seq_i), .lat_i(lat_i),
    .unpiped_i(unpiped_i), .grant_o(grant_o), .hold_o(hold_o),
    .wb_valid_o(wb_valid_o), .wb_unit_o(wb_unit_o), .wb_seq_o(wb_seq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_unit(input int u, input bit rq, input bit np, input int lat, input int sq);
    req_i[u]               = rq;
    unpiped_i[u]           = np;
    lat_i[u*6 +: 6]        = 6'(lat);
    seq_i[u*8 +: 8]        = 8'(sq);
  endtask

  // integer 1 piped, add 4 piped, mul 6 piped, div 20 non-piped
  task automatic base_cfg();
    set_unit(0, 0, 0, 1, 0);
    set_unit(1, 0, 0, 4, 0);
    set_unit(2, 0, 1'b0, 6, 0);
    set_unit(3, 0, 1, 20, 0);
  endtask

  task automatic comb_check(input string tag, input logic [3:0] exp_g);
    #5;
    chk(grant_o == exp_g, {tag, " grant"}, grant_o, exp_g);
    chk(hold_o == (req_i & ~exp_g), "R3 hold", hold_o, req_i & ~exp_g);
  endtask

  task automatic wb_check(input string tag, input logic [1:0] u, input logic [7:0] s);
    @(negedge clk);
    chk(wb_valid_o == 1'b1, {tag, " wb_valid"}, wb_valid_o, 1);
    chk(wb_unit_o == u, {tag, " wb_unit"}, wb_unit_o, u);
    chk(wb_seq_o == s, {tag, " wb_seq"}, wb_seq_o, s);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    base_cfg();
    set_unit(2, 1, 0, 6, 9);
    repeat (3) @(negedge clk);
    chk(wb_valid_o == 0 && wb_unit_o == 0 && wb_seq_o == 0, "R10 reset",
        {21'd0, wb_valid_o, wb_unit_o, wb_seq_o}, 0);
    req_i = '0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_idle();
    base_cfg();
    comb_check("R1 idle", 4'b0000);
    @(negedge clk);
    chk(wb_valid_o == 0, "R9 idle wb_valid", wb_valid_o, 0);
  endtask

  task automatic t_single();
    base_cfg();
    set_unit(0, 1, 0, 1, 5);
    comb_check("R2 single", 4'b0001);
    wb_check("R9 single", 2'd0, 8'd5);
  endtask

  task automatic t_class();
    base_cfg();
    set_unit(0, 1, 0, 1, 40);
    set_unit(1, 1, 0, 4, 41);
    set_unit(2, 1, 0, 6, 42);
    set_unit(3, 1, 1, 20, 50);
    comb_check("R4 all four", 4'b1000);
    wb_check("R4 all four", 2'd3, 8'd50);
    base_cfg();
    set_unit(2, 1, 0, 30, 7);
    set_unit(3, 1, 1, 20, 8);
    comb_check("R4 class over latency", 4'b1000);
    @(negedge clk);
  endtask

  task automatic t_latency();
    base_cfg();
    set_unit(0, 1, 0, 1, 1);
    set_unit(1, 1, 0, 4, 2);
    set_unit(2, 1, 0, 6, 3);
    comb_check("R5 latency", 4'b0100);
    wb_check("R5 latency", 2'd2, 8'd3);
  endtask

  task automatic t_age();
    base_cfg();
    set_unit(1, 1, 0, 4, 10);
    set_unit(2, 1, 0, 4, 9);
    comb_check("R6 older", 4'b0100);
    @(negedge clk);
    set_unit(1, 1, 0, 4, 250);
    set_unit(2, 1, 0, 4, 3);
    comb_check("R6 wrap", 4'b0010);
    wb_check("R6 wrap", 2'd1, 8'd250);
  endtask

  task automatic t_tie();
    base_cfg();
    set_unit(1, 1, 0, 4, 77);
    set_unit(2, 1, 0, 4, 77);
    set_unit(3, 1, 0, 4, 77);
    comb_check("R7 tie", 4'b0010);
    @(negedge clk);
  endtask

  task automatic t_nohist();
    base_cfg();
    set_unit(2, 1, 0, 6, 20);
    set_unit(3, 1, 1, 20, 21);
    comb_check("R8 first", 4'b1000);
    @(negedge clk);
    set_unit(3, 0, 1, 20, 21);
    comb_check("R8 after loser", 4'b0100);
    wb_check("R8 after loser", 2'd2, 8'd20);
    req_i = '0;
    @(negedge clk);
    chk(wb_valid_o == 0, "R9 drop wb_valid", wb_valid_o, 0);
    chk(wb_unit_o == 2 && wb_seq_o == 20, "R9 keep",
        {22'd0, wb_unit_o, wb_seq_o}, {22'd0, 2'd2, 8'd20});
  endtask

  initial begin
    req_i = '0; seq_i = '0; lat_i = '0; unpiped_i = '0;
    @(negedge clk);
    t_reset();
    t_idle();
    t_single();
    t_class();
    t_latency();
    t_age();
    t_tie();
    t_nohist();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule